// File: doc/BRIEF.md
# Accumulator ALU with Packed-BCD Adjust

This block is the arithmetic and logic unit of an accumulator-style 8-bit processor. It is purely combinational. From an operation code, the accumulator value, a second operand (a memory byte or another register routed in by the surrounding datapath), the incoming carry and overflow flags and the decimal-mode flag, it produces a result byte and fresh negative, overflow, zero and carry flags. The surrounding datapath chooses which of these to write back. The register file, addressing and flag write enables all sit outside.

Single-operand operations (increment, decrement, shifts, rotates) act on the second operand `mIn`. Two-operand operations combine `aIn` with `mIn`.

When decimal mode is on, add and subtract produce a packed-BCD result directly, with no separate adjust step. The adjust works one 4-bit digit at a time with a ripple carry between digits. Only the carry reflects the decimal outcome. Negative, overflow and zero still describe the raw binary sum.

Top module: `acc_alu`

## Requirements
- R1: Op code 0 (add), decimal off: `result` = aIn + mIn + carryIn modulo 256. `carryOut` is the unsigned carry out of bit 7. `ovfOut` flags signed overflow. `negOut` is result bit 7 and `zeroOut` is set when the result is 0.
- R2: Op code 1 (subtract), decimal off: `result` = aIn − mIn − (1 − carryIn) modulo 256. `carryOut` = 1 when no borrow occurred. `ovfOut` flags signed overflow. N and Z are taken from the result.
- R3: Op code 0, decimal on: each digit, least significant first, is the sum of the two digits plus the incoming digit carry. If that sum exceeds 9, 6 is added and a carry passes to the next digit. `carryOut` is the carry out of the top digit.
- R4: Op code 1, decimal on: each digit is the difference of the two digits minus the incoming digit borrow, where the first borrow is 1 − carryIn. A negative digit result has 6 subtracted and borrows from the next digit. `carryOut` = 1 when the top digit does not borrow.
- R5: In decimal mode, `negOut`, `ovfOut` and `zeroOut` of add and subtract equal those of the same operation with decimal off.
- R6: Op code 5 (compare): N, Z and C are set as for aIn − mIn with an implied carry of 1, so C = 1 when aIn ≥ mIn. `result` equals aIn, `ovfOut` equals overflowIn, and the decimal flag has no effect.
- R7: Op code 6 (bit test): `negOut` = mIn bit 7, `ovfOut` = mIn bit 6 and `zeroOut` = ((aIn AND mIn) == 0). `result` = aIn and `carryOut` = carryIn.
- R8: Op codes 2 (AND), 3 (OR) and 4 (XOR) produce the bitwise result of aIn with mIn and set N and Z from it. C and V pass through from carryIn and overflowIn.
- R9: Op codes 7 (increment) and 8 (decrement) give mIn + 1 or mIn − 1 modulo 256, set N and Z from that value, and pass C and V through.
- R10: Op code 9 (shift left) puts 0 into bit 0 and moves mIn bit 7 to C. Op code 10 (shift right) puts 0 into bit 7, moves mIn bit 0 to C and so always gives N = 0. V passes through for both.
- R11: Op code 11 (rotate left) puts carryIn into bit 0 and moves bit 7 to C. Op code 12 (rotate right) puts carryIn into bit 7 and moves bit 0 to C.
- R12: In decimal mode, digits above 9 follow exactly the same R3/R4 rules and give a fixed result (for example $0F + $0F with carry 0 gives $14, C = 0).
- R13: Op codes 13 to 15 return aIn, set N and Z from aIn, and pass C and V through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 4 | Operation code (see requirements) |
| aIn | input | 8 | Accumulator operand |
| mIn | input | 8 | Second operand; the source for single-operand operations |
| carryIn | input | 1 | Current carry flag |
| overflowIn | input | 1 | Current overflow flag |
| decimalEn | input | 1 | Decimal-mode flag |
| result | output | 8 | Result byte |
| negOut | output | 1 | New negative flag |
| ovfOut | output | 1 | New overflow flag |
| zeroOut | output | 1 | New zero flag |
| carryOut | output | 1 | New carry flag |

## Verification
The unit holds no registers, so every result and flag belongs to the same cycle as the inputs that produced it, with zero cycles of latency. The driver applies a stimulus just after a rising edge and queues the value the reference model expects. The monitor pops that entry at the following falling edge, half a period later, when the outputs have settled and before the next stimulus arrives. Directed cases cover digit-carry and digit-borrow chains, non-BCD digits, zero and overflow boundaries and the pass-through flags. After them, a long pseudo-random sweep runs over every op code with and without decimal mode.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_SUB = 4'd1,  OP_AND = 4'd2,  OP_OR  = 4'd3,
    OP_XOR = 4'd4,  OP_CMP = 4'd5,  OP_BIT = 4'd6,  OP_INC = 4'd7,
    OP_DEC = 4'd8,  OP_ASL = 4'd9,  OP_LSR = 4'd10, OP_ROL = 4'd11,
    OP_ROR = 4'd12
  } aluOpE;

  typedef enum logic [2:0] {
    U_ARITH, U_LOGIC, U_INCDEC, U_SHIFT, U_PASS
  } unitSelE;

  typedef enum logic [1:0] {
    L_AND, L_OR, L_XOR
  } logicSelE;

  // strobes handed from the decoder to the datapath
  typedef struct packed {
    unitSelE  unit;
    logicSelE logicOp;
    logic     invertM;   // subtract path: use one's complement of M
    logic     compare;   // forced carry-in, result keeps A, V passes
    logic     bcdOk;     // decimal adjust allowed for this op
    logic     bitTest;   // N/V from operand, Z from A AND M
    logic     decr;      // decrement instead of increment
    logic     shLeft;    // shift direction
    logic     rotate;    // carry enters the vacated bit
  } aluStrobeS;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [3:0] opSel,
  output aluStrobeS  strobe
);

  always_comb begin
    strobe = '{unit: U_PASS, logicOp: L_AND, default: 1'b0};
    case (opSel)
      OP_ADD: begin strobe.unit = U_ARITH; strobe.bcdOk = 1'b1; end
      OP_SUB: begin strobe.unit = U_ARITH; strobe.bcdOk = 1'b1; strobe.invertM = 1'b1; end
      OP_CMP: begin strobe.unit = U_ARITH; strobe.invertM = 1'b1; strobe.compare = 1'b1; end
      OP_AND: begin strobe.unit = U_LOGIC; strobe.logicOp = L_AND; end
      OP_OR:  begin strobe.unit = U_LOGIC; strobe.logicOp = L_OR; end
      OP_XOR: begin strobe.unit = U_LOGIC; strobe.logicOp = L_XOR; end
      OP_BIT: begin strobe.unit = U_LOGIC; strobe.logicOp = L_AND; strobe.bitTest = 1'b1; end
      OP_INC: strobe.unit = U_INCDEC;
      OP_DEC: begin strobe.unit = U_INCDEC; strobe.decr = 1'b1; end
      OP_ASL: begin strobe.unit = U_SHIFT; strobe.shLeft = 1'b1; end
      OP_LSR: strobe.unit = U_SHIFT;
      OP_ROL: begin strobe.unit = U_SHIFT; strobe.shLeft = 1'b1; strobe.rotate = 1'b1; end
      OP_ROR: begin strobe.unit = U_SHIFT; strobe.rotate = 1'b1; end
      default: strobe.unit = U_PASS;
    endcase
  end

endmodule

// File: rtl/acc_alu_bcd.sv
module acc_alu_bcd #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] mIn,
  input  logic              carryIn,
  input  logic              subtract,
  output logic [DATA_W-1:0] bcdRes,
  output logic              bcdCarry
);
  localparam int NDIG = DATA_W / 4;

  // digitCy: carry for add, "no borrow" for subtract
  logic [NDIG:0] digitCy;
  assign digitCy[0] = carryIn;

  for (genvar k = 0; k < NDIG; k++) begin : g_digit
    logic [4:0] raw;
    logic       adjust;
    always_comb begin
      if (subtract) begin
        raw    = {1'b0, aIn[4*k +: 4]} - {1'b0, mIn[4*k +: 4]} - {4'd0, ~digitCy[k]};
        adjust = raw[4];
        bcdRes[4*k +: 4] = adjust ? (raw[3:0] - 4'd6) : raw[3:0];
        digitCy[k+1] = ~adjust;
      end else begin
        raw    = {1'b0, aIn[4*k +: 4]} + {1'b0, mIn[4*k +: 4]} + {4'd0, digitCy[k]};
        adjust = (raw > 5'd9);
        bcdRes[4*k +: 4] = adjust ? (raw[3:0] + 4'd6) : raw[3:0];
        digitCy[k+1] = adjust;
      end
    end
  end

  assign bcdCarry = digitCy[NDIG];

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  aluStrobeS         strobe,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] mIn,
  input  logic              carryIn,
  input  logic              overflowIn,
  input  logic              decimalEn,
  output logic [DATA_W-1:0] result,
  output logic              negOut,
  output logic              ovfOut,
  output logic              zeroOut,
  output logic              carryOut
);
  localparam int MSB  = DATA_W - 1;
  localparam int NDIG = DATA_W / 4;

  logic [DATA_W-1:0] opB, logicRes, incDecRes, shiftRes, flagVal, bcdRes;
  logic [DATA_W:0]   sumFull;
  logic              addCin, binV, shiftC, useBcd, bcdCarry;

  assign opB    = strobe.invertM ? ~mIn : mIn;
  assign addCin = strobe.compare ? 1'b1 : carryIn;
  assign sumFull = {1'b0, aIn} + {1'b0, opB} + {{DATA_W{1'b0}}, addCin};
  assign binV   = (aIn[MSB] == opB[MSB]) && (sumFull[MSB] != aIn[MSB]);
  assign useBcd = strobe.bcdOk && decimalEn;

  acc_alu_bcd #(.DATA_W(DATA_W)) bcd_i (
    .aIn(aIn), .mIn(mIn), .carryIn(carryIn), .subtract(strobe.invertM),
    .bcdRes(bcdRes), .bcdCarry(bcdCarry)
  );

  always_comb begin
    case (strobe.logicOp)
      L_OR:    logicRes = aIn | mIn;
      L_XOR:   logicRes = aIn ^ mIn;
      default: logicRes = aIn & mIn;
    endcase
    incDecRes = strobe.decr ? (mIn - 1'b1) : (mIn + 1'b1);
    if (strobe.shLeft) begin
      shiftRes = {mIn[MSB-1:0], strobe.rotate & carryIn};
      shiftC   = mIn[MSB];
    end else begin
      shiftRes = {strobe.rotate & carryIn, mIn[MSB:1]};
      shiftC   = mIn[0];
    end
  end

  always_comb begin
    result   = aIn;
    flagVal  = aIn;
    ovfOut   = overflowIn;
    carryOut = carryIn;
    case (strobe.unit)
      U_ARITH: begin
        flagVal  = sumFull[MSB:0];
        result   = strobe.compare ? aIn : (useBcd ? bcdRes : sumFull[MSB:0]);
        carryOut = useBcd ? bcdCarry : sumFull[DATA_W];
        ovfOut   = strobe.compare ? overflowIn : binV;
      end
      U_LOGIC: begin
        flagVal = logicRes;
        result  = strobe.bitTest ? aIn : logicRes;
        if (strobe.bitTest) ovfOut = mIn[MSB-1];
      end
      U_INCDEC: begin
        flagVal = incDecRes;
        result  = incDecRes;
      end
      U_SHIFT: begin
        flagVal  = shiftRes;
        result   = shiftRes;
        carryOut = shiftC;
      end
      default: ;
    endcase
    negOut  = strobe.bitTest ? mIn[MSB] : flagVal[MSB];
    zeroOut = (flagVal == '0);
  end

  function automatic logic digitsValid(input logic [DATA_W-1:0] x);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < NDIG; k++) if (x[4*k +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // checks next to the logic they guard
  always_comb begin
    if (strobe.unit == U_ARITH && !strobe.invertM && !useBcd)
      a_r1_add_sum: assert ({carryOut, result} == {1'b0, aIn} + {1'b0, mIn} + {{DATA_W{1'b0}}, carryIn});
    if (useBcd && digitsValid(aIn) && digitsValid(mIn))
      a_r3_bcd_digits: assert (digitsValid(result));
    if (strobe.compare)
      a_r6_cmp_keeps: assert (result == aIn && ovfOut == overflowIn);
    if (strobe.unit == U_LOGIC || strobe.unit == U_INCDEC)
      a_r8_carry_pass: assert (carryOut == carryIn);
    if (strobe.unit == U_SHIFT && !strobe.shLeft)
      a_r10_right_neg: assert (negOut == (strobe.rotate & carryIn));
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] mIn,
  input  logic              carryIn,
  input  logic              overflowIn,
  input  logic              decimalEn,
  output logic [DATA_W-1:0] result,
  output logic              negOut,
  output logic              ovfOut,
  output logic              zeroOut,
  output logic              carryOut
);

  aluStrobeS strobe;

  acc_alu_ctrl ctrl_i (.opSel(opSel), .strobe(strobe));

  acc_alu_dp #(.DATA_W(DATA_W)) dp_i (
    .strobe(strobe), .aIn(aIn), .mIn(mIn), .carryIn(carryIn),
    .overflowIn(overflowIn), .decimalEn(decimalEn), .result(result),
    .negOut(negOut), .ovfOut(ovfOut), .zeroOut(zeroOut), .carryOut(carryOut)
  );

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  typedef struct {
    logic [7:0] res;
    logic n, v, z, c;
    string tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [3:0] opSel = '0;
  logic [7:0] aIn = '0, mIn = '0;
  logic carryIn = 1'b0, overflowIn = 1'b0, decimalEn = 1'b0;
  logic [7:0] result;
  logic negOut, ovfOut, zeroOut, carryOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  expT sbQ[$];

  acc_alu dut_i (
    .opSel(opSel), .aIn(aIn), .mIn(mIn), .carryIn(carryIn),
    .overflowIn(overflowIn), .decimalEn(decimalEn), .result(result),
    .negOut(negOut), .ovfOut(ovfOut), .zeroOut(zeroOut), .carryOut(carryOut)
  );

  function automatic bit hasBadDigit(int x);
    return ((x % 16) > 9) || ((x / 16) > 9);
  endfunction

  function automatic expT refModel(int op, int a, int m, int c, int d, int v);
    expT e;
    int bin, lo, hi, r;
    e.v = v[0]; e.c = c[0]; r = a; e.tag = "R13";
    case (op)
      0: begin
        bin = a + m + c;
        r = bin % 256;
        e.c = (bin > 255);
        e.v = (((a ^ r) & (m ^ r) & 128) != 0);
        e.tag = "R1";
        if (d != 0) begin
          lo = a % 16 + m % 16 + c;
          if (lo > 9) lo = lo + 6;
          hi = a / 16 + m / 16 + ((lo > 15) ? 1 : 0);
          if (hi > 9) hi = hi + 6;
          e.c = (hi > 15);
          e.tag = hasBadDigit(a) || hasBadDigit(m) ? "R12" : "R3,R5";
        end
      end
      1: begin
        bin = a - m - (1 - c);
        r = bin & 255;
        e.c = (bin >= 0);
        e.v = (((a ^ m) & (a ^ r) & 128) != 0);
        e.tag = "R2";
        if (d != 0) begin
          lo = a % 16 - m % 16 - (1 - c);
          if (lo < 0) lo = lo - 6;
          hi = a / 16 - m / 16 - ((lo < 0) ? 1 : 0);
          if (hi < 0) hi = hi - 6;
          e.c = (hi >= 0);
          e.tag = hasBadDigit(a) || hasBadDigit(m) ? "R12" : "R4,R5";
        end
      end
      2: begin r = a & m; e.tag = "R8"; end
      3: begin r = a | m; e.tag = "R8"; end
      4: begin r = a ^ m; e.tag = "R8"; end
      5: begin r = (a - m) & 255; e.c = (a >= m); e.tag = "R6"; end
      6: begin r = a & m; e.tag = "R7"; end
      7: begin r = (m + 1) & 255; e.tag = "R9"; end
      8: begin r = (m + 255) & 255; e.tag = "R9"; end
      9: begin r = (m * 2) & 255; e.c = (m >= 128); e.tag = "R10"; end
      10: begin r = m / 2; e.c = m[0]; e.tag = "R10"; end
      11: begin r = (m * 2 + c) & 255; e.c = (m >= 128); e.tag = "R11"; end
      12: begin r = m / 2 + c * 128; e.c = m[0]; e.tag = "R11"; end
      default: r = a;
    endcase
    e.n = (r >= 128);
    e.z = (r == 0);
    e.res = r[7:0];
    if (op == 0 && d != 0) e.res = 8'(((hi & 15) << 4) | (lo & 15));
    if (op == 1 && d != 0) e.res = 8'(((hi & 15) << 4) | (lo & 15));
    if (op == 5) e.res = a[7:0];
    if (op == 6) begin
      e.res = a[7:0]; e.n = m[7]; e.v = m[6]; e.z = ((a & m) == 0);
    end
    return e;
  endfunction

  // driver: apply just after the rising edge, queue the expectation
  task automatic drive(int op, int a, int m, int c, int d, int v);
    @(posedge clk);
    #1;
    opSel = op[3:0]; aIn = a[7:0]; mIn = m[7:0];
    carryIn = c[0]; decimalEn = d[0]; overflowIn = v[0];
    sbQ.push_back(refModel(op, a, m, c, d, v));
  endtask

  // directed check with a literal expected value (independent of refModel)
  task automatic driveLit(int op, int a, int m, int c, int d, int v,
                          int er, int en, int ev, int ez, int ec, string tag);
    expT e;
    @(posedge clk);
    #1;
    opSel = op[3:0]; aIn = a[7:0]; mIn = m[7:0];
    carryIn = c[0]; decimalEn = d[0]; overflowIn = v[0];
    e.res = er[7:0]; e.n = en[0]; e.v = ev[0]; e.z = ez[0]; e.c = ec[0]; e.tag = tag;
    sbQ.push_back(e);
  endtask

  // monitor: compare half a period after the stimulus
  always @(negedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      expT e;
      e = sbQ.pop_front();
      checks++;
      if (result !== e.res || negOut !== e.n || ovfOut !== e.v ||
          zeroOut !== e.z || carryOut !== e.c) begin
        errors++;
        $display("FAIL %s: op=%0d a=%02h m=%02h c=%0b d=%0b got res=%02h nvzc=%b%b%b%b expected res=%02h nvzc=%b%b%b%b",
                 e.tag, opSel, aIn, mIn, carryIn, decimalEn, result, negOut, ovfOut,
                 zeroOut, carryOut, e.res, e.n, e.v, e.z, e.c);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 idle state: all-zero inputs add to zero
    driveLit(0, 8'h00, 8'h00, 0, 0, 0, 8'h00, 0, 0, 1, 0, "R1");
    // R1 carry out with zero result
    driveLit(0, 8'hFF, 8'h01, 0, 0, 0, 8'h00, 0, 0, 1, 1, "R1");
    // R1 signed overflow
    driveLit(0, 8'h7F, 8'h01, 0, 0, 0, 8'h80, 1, 1, 0, 0, "R1");
    // R2 borrow in, no-borrow out
    driveLit(1, 8'h50, 8'h10, 0, 0, 0, 8'h3F, 0, 0, 0, 1, "R2");
    driveLit(1, 8'h80, 8'h01, 1, 0, 0, 8'h7F, 0, 1, 0, 1, "R2");
    // R3/R5 decimal add: 58+46 = 104, flags from binary 9E
    driveLit(0, 8'h58, 8'h46, 0, 1, 0, 8'h04, 1, 1, 0, 1, "R3,R5");
    driveLit(0, 8'h99, 8'h01, 0, 1, 0, 8'h00, 1, 0, 0, 1, "R3,R5");
    // R4 decimal subtract with and without top borrow
    driveLit(1, 8'h46, 8'h12, 1, 1, 0, 8'h34, 0, 0, 0, 1, "R4");
    driveLit(1, 8'h12, 8'h21, 1, 1, 0, 8'h91, 1, 0, 0, 0, "R4,R5");
    driveLit(1, 8'h00, 8'h00, 0, 1, 0, 8'h99, 1, 0, 0, 0, "R4");
    // R12 non-BCD digits
    driveLit(0, 8'h0F, 8'h0F, 0, 1, 0, 8'h14, 0, 0, 0, 0, "R12");
    // R6 compare ignores decimal, keeps A and V
    driveLit(5, 8'h40, 8'h40, 0, 1, 1, 8'h40, 0, 1, 1, 1, "R6");
    driveLit(5, 8'h10, 8'h20, 1, 0, 0, 8'h10, 1, 0, 0, 0, "R6");
    // R7 bit test
    driveLit(6, 8'h0F, 8'hC0, 1, 0, 0, 8'h0F, 1, 1, 1, 1, "R7");
    // R8 logic keeps C and V
    driveLit(4, 8'hFF, 8'hFF, 1, 1, 1, 8'h00, 0, 1, 1, 1, "R8");
    // R9 wrap
    driveLit(7, 8'h00, 8'hFF, 0, 0, 0, 8'h00, 0, 0, 1, 0, "R9");
    driveLit(8, 8'h00, 8'h00, 1, 0, 1, 8'hFF, 1, 1, 0, 1, "R9");
    // R10 shifts
    driveLit(9, 8'h00, 8'h81, 1, 0, 0, 8'h02, 0, 0, 0, 1, "R10");
    driveLit(10, 8'h00, 8'h01, 1, 0, 0, 8'h00, 0, 0, 1, 1, "R10");
    // R11 rotates through carry
    driveLit(11, 8'h00, 8'h80, 1, 0, 0, 8'h01, 0, 0, 0, 1, "R11");
    driveLit(12, 8'h00, 8'h01, 1, 0, 0, 8'h80, 1, 0, 0, 1, "R11");
    // R13 unused code
    driveLit(14, 8'h00, 8'h55, 1, 1, 1, 8'h00, 0, 1, 1, 1, "R13");
    // sweep over every op code
    seed = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      seed = seed * 1103515245 + 12345;
      drive(i % 16, (seed >>> 8) & 255, (seed >>> 16) & 255,
            (seed >>> 3) & 1, (seed >>> 5) & 1, (seed >>> 7) & 1);
    end
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule